// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block routes a set of external interrupt lines (24 by default) to processors. Each line owns one entry of a redirection table that sets the interrupt vector, the destination processor ID, a mask, the trigger mode (edge or level) and the input polarity. Software reaches every internal register through two 32-bit words: it writes a register index at offset 0x00, then reads or writes the selected register through a data window at offset 0x10. Besides the table, the window exposes an identification register and a version register that reports how many entries exist.

Each line is reduced to a request. Edge lines latch an active-going transition. Level lines request while active, but once delivered they stay quiet until an end-of-interrupt carrying their vector arrives. A small dispatcher has two states. In IDLE it waits for any unmasked request, picks the lowest-numbered one, latches its vector and destination, and takes the transition IDLE to OFFER. In OFFER it presents the message on a valid/ready port and holds it there. The acceptance (valid and ready together) takes the transition OFFER to IDLE, which retires the request, so the dispatcher spends one cycle in IDLE between messages.

Top module: `irq_router`

## Requirements
- R1: A write to offset 0x00 sets the 8-bit index register, and a read of offset 0x00 returns it in bits 7:0. Reads and writes at offset 0x10 reach the register that the index selects. Any other offset reads zero and ignores writes.
- R2: Index 0x00 reads the unit ID parameter in bits 31:24, with all other bits zero.
- R3: Index 0x01 reads the highest entry number (entries minus one, 23 by default) in bits 23:16 and the version parameter (0x20 by default) in bits 7:0, with all other bits zero.
- R4: Entry i has its low word at index 0x10+2i and its high word at index 0x11+2i. The low word holds the vector in bits 7:0, active-low polarity in bit 13, level trigger in bit 15 and the mask in bit 16. The high word holds the destination in bits 31:24. All other bits read zero.
- R5: After reset every entry has its mask set and all other fields zero, and the index register is zero. Indices 0x02 to 0x0F and 0x40 and above read zero and ignore writes.
- R6: An unmasked edge line produces exactly one message for each transition of its input to the active level. With bit 13 clear the active level is high; with bit 13 set it is low.
- R7: A masked line produces no message. An edge that arrives while the line is masked is discarded and is not delivered after the line is unmasked.
- R8: An unmasked level line produces a message while its input is active. After delivery it sends no further message until an end-of-interrupt carrying its vector arrives. After that end-of-interrupt it sends again if the input is still active.
- R9: When several lines request at once, the lowest-numbered line is sent first.
- R10: msg_valid stays high, with msg_vector and msg_dest unchanged, until msg_ready is seen. In the cycle after an acceptance msg_valid is low.
- R11: A message carries the vector and destination programmed in the entry of the line that raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset: 0x00 index, 0x10 data window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq_in | input | 24 | Interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination ID |

## Verification
The main routing path is driven from a table of line programmings. The table covers the lowest and highest line, active-high and active-low polarity, edge and level trigger, and extreme vector and destination values, so that an error in the polarity or trigger decode, or in the entry-to-line pairing, shows up as a missing message or a wrong field. Directed patterns then separate the finer behaviours. Simultaneous edges on two lines check the ordering. A pulse while masked followed by an unmask checks that the edge is discarded. A level line held active across an end-of-interrupt checks that the line is blocked after delivery and re-armed by the end-of-interrupt. An all-ones write checks which bits of an entry are stored.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam logic [4:0] OFS_INDEX  = 5'h00;
    localparam logic [4:0] OFS_WINDOW = 5'h10;
    localparam int         TBL_BASE   = 16;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } disp_state_e;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int         N       = 24,
    parameter logic [7:0] UNIT_ID = 8'h0C,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [4:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [N-1:0]        ent_mask,
    output logic [N-1:0]        ent_level,
    output logic [N-1:0]        ent_low,
    output logic [N-1:0][7:0]   ent_vec,
    output logic [N-1:0][7:0]   ent_dest
);
    localparam int EW      = (N > 1) ? $clog2(N) : 1;
    localparam int TBL_END = TBL_BASE + 2 * N;

    logic [7:0]    idx_q;
    logic [7:0]    off;
    logic          in_tbl;
    logic          hi_word;
    logic [EW-1:0] ent;
    logic [31:0]   window;

    assign off     = idx_q - 8'(TBL_BASE);
    assign in_tbl  = (int'(idx_q) >= TBL_BASE) && (int'(idx_q) < TBL_END);
    assign hi_word = idx_q[0];
    assign ent     = off[EW:1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            ent_mask  <= '1;
            ent_level <= '0;
            ent_low   <= '0;
            ent_vec   <= '0;
            ent_dest  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_INDEX) begin
                idx_q <= reg_wdata[7:0];
            end else if (reg_addr == OFS_WINDOW && in_tbl) begin
                if (!hi_word) begin
                    ent_vec[ent]   <= reg_wdata[7:0];
                    ent_low[ent]   <= reg_wdata[13];
                    ent_level[ent] <= reg_wdata[15];
                    ent_mask[ent]  <= reg_wdata[16];
                end else begin
                    ent_dest[ent]  <= reg_wdata[31:24];
                end
            end
        end
    end

    always_comb begin
        window = '0;
        if (idx_q == 8'h00) begin
            window = {UNIT_ID, 24'h0};
        end else if (idx_q == 8'h01) begin
            window = {8'h0, 8'(N - 1), 8'h0, VERSION};
        end else if (in_tbl && !hi_word) begin
            window = {15'h0, ent_mask[ent], ent_level[ent], 1'b0,
                      ent_low[ent], 5'h0, ent_vec[ent]};
        end else if (in_tbl) begin
            window = {ent_dest[ent], 24'h0};
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_INDEX:  reg_rdata = {24'h0, idx_q};
            OFS_WINDOW: reg_rdata = window;
            default:    reg_rdata = '0;
        endcase
    end

    // R4: a low-word write lands in the selected entry's mask bit
    p_lo_write_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_WINDOW && in_tbl && !hi_word)
        |=> ent_mask[$past(ent)] == $past(reg_wdata[16]));

    // R1: the index only moves on a write to offset 0
    p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFS_INDEX) |=> $stable(idx_q));
endmodule

// File: rtl/irq_router_lines.sv
module irq_router_lines #(
    parameter int N = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_in,
    input  logic [N-1:0]      ent_mask,
    input  logic [N-1:0]      ent_level,
    input  logic [N-1:0]      ent_low,
    input  logic [N-1:0][7:0] ent_vec,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    input  logic [N-1:0]      deliver,
    output logic [N-1:0]      req
);
    logic [N-1:0] act;
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] infl_q;
    logic [N-1:0] eoi_hit;

    assign act = irq_in ^ ent_low;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign eoi_hit[i] = eoi_valid && (eoi_vector == ent_vec[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            infl_q <= '0;
        end else begin
            prev_q <= act;
            pend_q <= ~ent_level & ((pend_q & ~deliver) | (act & ~prev_q & ~ent_mask));
            infl_q <= ent_level & ((infl_q & ~eoi_hit) | deliver);
        end
    end

    assign req = ~ent_mask & ((~ent_level & pend_q) | (ent_level & act & ~infl_q));

    // R9: the dispatcher retires at most one line per cycle
    p_one_deliver_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deliver));

    // R8: a delivered level line stays blocked until a matching end-of-interrupt
    p_hold_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(infl_q & ~eoi_hit & ent_level) & ent_level & ~infl_q) == '0));
endmodule

// File: rtl/irq_router_disp.sv
module irq_router_disp
    import irq_router_pkg::*;
#(
    parameter int N = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic [N-1:0][7:0] ent_vec,
    input  logic [N-1:0][7:0] ent_dest,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest,
    output logic [N-1:0]      deliver
);
    localparam int EW = (N > 1) ? $clog2(N) : 1;

    disp_state_e   state_q, state_d;
    logic [EW-1:0] pick;
    logic          any_req;
    logic [EW-1:0] line_q;
    logic [7:0]    vec_q;
    logic [7:0]    dest_q;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) pick = EW'(i);
        end
    end
    assign any_req = |req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req)   state_d = ST_OFFER;
            ST_OFFER: if (msg_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            vec_q  <= '0;
            dest_q <= '0;
        end else if (state_q == ST_IDLE && any_req) begin
            line_q <= pick;
            vec_q  <= ent_vec[pick];
            dest_q <= ent_dest[pick];
        end
    end

    always_comb begin
        msg_valid  = 1'b0;
        deliver    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                msg_valid = 1'b1;
                if (msg_ready) deliver[line_q] = 1'b1;
            end
            default: ;
        endcase
    end
    assign msg_vector = vec_q;
    assign msg_dest   = dest_q;

    // R10: an unaccepted message stays put
    p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         N       = 24,
    parameter logic [7:0] UNIT_ID = 8'h0C,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [N-1:0]  irq_in,
    input  logic          eoi_valid,
    input  logic [7:0]    eoi_vector,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [7:0]    msg_vector,
    output logic [7:0]    msg_dest
);
    logic [N-1:0]      ent_mask;
    logic [N-1:0]      ent_level;
    logic [N-1:0]      ent_low;
    logic [N-1:0][7:0] ent_vec;
    logic [N-1:0][7:0] ent_dest;
    logic [N-1:0]      req;
    logic [N-1:0]      deliver;

    irq_router_regs #(.N(N), .UNIT_ID(UNIT_ID), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_mask(ent_mask),
        .ent_level(ent_level), .ent_low(ent_low), .ent_vec(ent_vec), .ent_dest(ent_dest)
    );

    irq_router_lines #(.N(N)) u_lines (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ent_mask(ent_mask),
        .ent_level(ent_level), .ent_low(ent_low), .ent_vec(ent_vec),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .deliver(deliver), .req(req)
    );

    irq_router_disp #(.N(N)) u_disp (
        .clk(clk), .rst_n(rst_n), .req(req), .ent_vec(ent_vec), .ent_dest(ent_dest),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .deliver(deliver)
    );

    // R10: one idle cycle follows every acceptance
    p_gap_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = 5'h0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector;
    logic [7:0]    msg_dest;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest)
    );

    // line[25:21], level[20], active-low[19], vector[15:8], dest[7:0]
    localparam logic [25:0] CASES [6] = '{
        {5'd0,  1'b0, 1'b0, 3'b0, 8'h30, 8'h01},
        {5'd23, 1'b0, 1'b0, 3'b0, 8'h47, 8'hA5},
        {5'd9,  1'b1, 1'b0, 3'b0, 8'h51, 8'h02},
        {5'd14, 1'b0, 1'b1, 3'b0, 8'h62, 8'h7F},
        {5'd18, 1'b1, 1'b1, 3'b0, 8'h99, 8'hFE},
        {5'd1,  1'b0, 1'b0, 3'b0, 8'hFF, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        wr(5'h00, {24'h0, idx});
        wr(5'h10, d);
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        wr(5'h00, {24'h0, idx});
        reg_addr = 5'h10;
        #1 d = reg_rdata;
    endtask

    task automatic expect_msg(input string tag, input logic [7:0] ev, input logic [7:0] ed);
        bit seen = 0;
        for (int k = 0; k < 8 && !seen; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        chk(seen, tag, {31'h0, seen}, 32'h1);
        if (seen) begin
            chk(msg_vector == ev && msg_dest == ed, tag, {16'h0, msg_vector, msg_dest}, {16'h0, ev, ed});
            @(negedge clk);
            chk(msg_valid && msg_vector == ev && msg_dest == ed, "R10 hold",
                {15'h0, msg_valid, msg_vector, msg_dest}, {15'h0, 1'b1, ev, ed});
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
            chk(!msg_valid, "R10 gap", {31'h0, msg_valid}, 32'h0);
        end
    endtask

    task automatic expect_none(input string tag, input int cyc);
        bit bad = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (msg_valid) bad = 1;
        end
        chk(!bad, tag, {31'h0, bad}, 32'h0);
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state and fixed registers
        reg_addr = 5'h00; #1;
        chk(reg_rdata == 32'h0, "R5 index reset", reg_rdata, 32'h0);
        rd_idx(8'h00, d); chk(d == 32'h0C00_0000, "R2 id", d, 32'h0C00_0000);
        rd_idx(8'h01, d); chk(d == 32'h0017_0020, "R3 version", d, 32'h0017_0020);
        rd_idx(8'h10, d); chk(d == 32'h0001_0000, "R5 entry0 masked", d, 32'h0001_0000);
        rd_idx(8'h3E, d); chk(d == 32'h0001_0000, "R5 entry23 masked", d, 32'h0001_0000);
        rd_idx(8'h3F, d); chk(d == 32'h0, "R5 entry23 dest", d, 32'h0);
        wr_idx(8'h05, 32'hFFFF_FFFF);
        rd_idx(8'h05, d); chk(d == 32'h0, "R5 unimplemented 0x05", d, 32'h0);
        wr_idx(8'h40, 32'hFFFF_FFFF);
        rd_idx(8'h40, d); chk(d == 32'h0, "R5 unimplemented 0x40", d, 32'h0);
        wr(5'h00, 32'h0000_0012);
        reg_addr = 5'h00; #1;
        chk(reg_rdata == 32'h12, "R1 index readback", reg_rdata, 32'h12);
        reg_addr = 5'h08; #1;
        chk(reg_rdata == 32'h0, "R1 other offset", reg_rdata, 32'h0);

        // R4 field layout with all-ones writes on entry 2
        wr_idx(8'h14, 32'hFFFF_FFFF);
        rd_idx(8'h14, d); chk(d == 32'h0001_A0FF, "R4 low word bits", d, 32'h0001_A0FF);
        wr_idx(8'h15, 32'hFFFF_FFFF);
        rd_idx(8'h15, d); chk(d == 32'hFF00_0000, "R4 high word bits", d, 32'hFF00_0000);
        wr_idx(8'h14, 32'h0001_0000);
        wr_idx(8'h15, 32'h0);
        expect_none("R7 masked quiet", 4);

        // Table-driven routing: R6, R8, R11
        for (int r = 0; r < 6; r++) begin
            logic [4:0]  ln;
            logic        lv, lo;
            logic [7:0]  vv, dd, ix;
            ln = CASES[r][25:21]; lv = CASES[r][20]; lo = CASES[r][19];
            vv = CASES[r][15:8];  dd = CASES[r][7:0];
            ix = 8'h10 + {2'b0, ln, 1'b0};
            wr_idx(ix, {15'h0, 1'b1, lv, 1'b0, lo, 5'h0, vv});
            wr_idx(ix + 8'h1, {dd, 24'h0});
            irq_in[ln] = lo;
            repeat (2) @(negedge clk);
            wr_idx(ix, {15'h0, 1'b0, lv, 1'b0, lo, 5'h0, vv});
            expect_none("R6 idle line quiet", 3);
            irq_in[ln] = ~lo;
            if (!lv) begin
                @(negedge clk);
                irq_in[ln] = lo;
            end
            expect_msg("R11 routed fields", vv, dd);
            irq_in[ln] = lo;
            if (lv) eoi(vv);
            expect_none("R6 single message", 4);
            wr_idx(ix, {15'h0, 1'b1, lv, 1'b0, lo, 5'h0, vv});
        end

        // R9: simultaneous edges on lines 3 and 7
        wr_idx(8'h17, 32'h1100_0000);
        wr_idx(8'h1F, 32'h2200_0000);
        wr_idx(8'h16, 32'h0000_0033);
        wr_idx(8'h1E, 32'h0000_0077);
        @(negedge clk);
        irq_in[3] = 1'b1; irq_in[7] = 1'b1;
        @(negedge clk);
        irq_in[3] = 1'b0; irq_in[7] = 1'b0;
        expect_msg("R9 lower line first", 8'h33, 8'h11);
        expect_msg("R9 higher line second", 8'h77, 8'h22);
        expect_none("R9 no extra", 4);

        // R7: edge while masked is discarded
        wr_idx(8'h16, 32'h0001_0033);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        expect_none("R7 masked edge", 4);
        wr_idx(8'h16, 32'h0000_0033);
        expect_none("R7 discarded after unmask", 6);

        // R8: level blocked until EOI, re-sent while still active
        wr_idx(8'h27, 32'h4400_0000);
        wr_idx(8'h26, 32'h0000_8055);
        @(negedge clk); irq_in[11] = 1'b1;
        expect_msg("R8 level first", 8'h55, 8'h44);
        expect_none("R8 blocked before EOI", 8);
        eoi(8'h56);
        expect_none("R8 other vector EOI", 6);
        eoi(8'h55);
        expect_msg("R8 resend after EOI", 8'h55, 8'h44);
        irq_in[11] = 1'b0;
        eoi(8'h55);
        expect_none("R8 inactive after EOI", 6);

        done = 1;
        summary();
    end
endmodule